// File: doc/BRIEF.md
# Oversampled UART Receiver with Error-Tagged Receive Queue

This block is the receive side of an asynchronous serial port. It watches a serial line at sixteen samples per bit, driven by an external tick. It confirms each start bit at mid-bit and assembles 8-bit characters, least significant bit first, with an optional even or odd parity bit and one stop bit. Every character goes into a 16-entry queue together with three error tags: parity, framing and break.

Software reads an 8-bit line status value. Reading it clears the sticky bits. The parity, framing and break bits describe the character currently at the head of the queue, not the one that arrived last. The status also carries a data-ready bit and an overrun bit, plus two transmitter-empty bits that follow status inputs from a separate transmitter. Its top bit is a summary bit, which stays set while any errored character is still queued.

After a bad stop bit, the receiver resynchronises by treating the low stop bit as the start of the next character. After a break, the receiver waits for the line to go high before it accepts a new character.

Top module: `uart_rx_lsr`

## Requirements
- R1: A character is a low start bit, 8 data bits sent least significant bit first, an optional parity bit and one stop bit, each lasting 16 ticks. A correctly framed character is queued with its data shown on `rx_data` when it reaches the head.
- R2: A low level that is high again when re-sampled 8 ticks after it was detected is a false start. Nothing is queued.
- R3: With `par_en`=1, the expected parity bit is the XOR of the data bits, inverted when `par_odd`=1. A mismatch tags the character with a parity error, which is shown in status bit 2.
- R4: A stop bit sampled as 0 tags the character with a framing error, shown in status bit 3. That low stop bit is then used as the start bit of the next character, with no mid-bit re-check.
- R5: A character whose start, data, parity and stop samples are all low is a break. It is queued once, as data 0x00 with status bits 4 and 3 set and bit 2 clear. No further character is accepted until the line is high again.
- R6: Status bits 2, 3 and 4 show the tags of the character at the head of the queue. They are 0 when the queue is empty.
- R7: A status read (`stat_rd`) clears bits 2 to 4 for the current head entry and clears bit 1. The next head entry shows its own tags.
- R8: Status bit 0 is 1 exactly when the queue is non-empty. `pop` removes the head entry. A `pop` on an empty queue has no effect.
- R9: The queue holds 16 characters. A character that arrives while the queue is full is dropped, and status bit 1 (overrun) is set until a status read.
- R10: Status bit 5 is the registered `thr_empty_in`. Bit 6 is the registered AND of `thr_empty_in` and `tsr_empty_in`. Both are 1 in reset, so with both inputs high and the queue empty the status reads 0x60.
- R11: Status bit 7 is set when an errored character (any of the parity, framing or break tags) is queued. A status read clears it only if no errored character remains in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial receive line, idle high |
| tick16 | input | 1 | Oversampling tick, 16 per bit time |
| par_en | input | 1 | Parity bit present when 1 |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| thr_empty_in | input | 1 | Transmit holding register is empty |
| tsr_empty_in | input | 1 | Transmit shift register is empty |
| stat_rd | input | 1 | Line status read strobe (read-clear) |
| stat_out | output | 8 | Line status value |
| pop | input | 1 | Remove the head character from the queue |
| rx_data | output | 8 | Data of the head character |

## Verification
A wrong tick count or a wrong shift order in the receiver corrupts the very next queued character. That error shows on `rx_data` within one character time. A tag written to the wrong entry, or a mask that is not cleared on `pop`, shows up as soon as the errored character moves to the head or leaves it. So the bench walks mixed queues of good and bad characters through reads and pops. A leaking error counter leaves status bit 7 stuck after the last errored character is gone, which is visible at the first read that follows.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DW = 8;
  localparam int BIT_IW = $clog2(DW);

  typedef struct packed {
    logic          brk;
    logic          ferr;
    logic          perr;
    logic [DW-1:0] data;
  } rx_entry_t;

  // expected parity bit for a data word
  function automatic logic exp_parity(logic [DW-1:0] d, logic odd);
    return (^d) ^ odd;
  endfunction

  function automatic logic entry_has_err(rx_entry_t e);
    return e.brk | e.ferr | e.perr;
  endfunction
endpackage

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx_in,
  input  logic      tick,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      push_req,
  output rx_entry_t push_entry,
  output logic      brk_hold
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID_C  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OVS - 1);
  localparam logic [BIT_IW-1:0] TOP_BIT = BIT_IW'(DW - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} rx_st_t;

  rx_st_t            st;
  logic [CW-1:0]     cnt;
  logic [BIT_IW-1:0] bit_i;
  logic [DW-1:0]     shreg;
  logic              par_q, all_low, rx_m, rx_s;
  logic              bit_done;

  assign bit_done = (cnt == LAST_C);
  assign brk_hold = (st == S_BRK);

  // two-stage synchroniser, idle high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_in;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      bit_i      <= '0;
      shreg      <= '0;
      par_q      <= 1'b0;
      all_low    <= 1'b1;
      push_req   <= 1'b0;
      push_entry <= '0;
    end else begin
      push_req <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: if (!rx_s) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: begin
            if (cnt == MID_C) begin
              cnt <= '0;
              if (rx_s) st <= S_IDLE;
              else begin
                st      <= S_DATA;
                bit_i   <= '0;
                all_low <= 1'b1;
              end
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (bit_done) begin
              cnt     <= '0;
              shreg   <= {rx_s, shreg[DW-1:1]};
              all_low <= all_low & ~rx_s;
              if (bit_i == TOP_BIT) st <= par_en ? S_PAR : S_STOP;
              else bit_i <= bit_i + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          S_PAR: begin
            if (bit_done) begin
              cnt     <= '0;
              par_q   <= rx_s;
              all_low <= all_low & ~rx_s;
              st      <= S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (bit_done) begin
              cnt      <= '0;
              push_req <= 1'b1;
              if (rx_s) begin
                push_entry.data <= shreg;
                push_entry.perr <= par_en & (par_q != exp_parity(shreg, par_odd));
                push_entry.ferr <= 1'b0;
                push_entry.brk  <= 1'b0;
                st <= S_IDLE;
              end else if (all_low) begin
                push_entry.data <= '0;
                push_entry.perr <= 1'b0;
                push_entry.ferr <= 1'b1;
                push_entry.brk  <= 1'b1;
                st <= S_BRK;
              end else begin
                // bad stop bit doubles as the next start bit
                push_entry.data <= shreg;
                push_entry.perr <= par_en & (par_q != exp_parity(shreg, par_odd));
                push_entry.ferr <= 1'b1;
                push_entry.brk  <= 1'b0;
                st      <= S_DATA;
                bit_i   <= '0;
                all_low <= 1'b1;
              end
            end else cnt <= cnt + 1'b1;
          end
          S_BRK: if (rx_s) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tag_fifo.sv
module uart_tag_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  rx_entry_t din,
  input  logic      pop,
  output rx_entry_t dout,
  output logic      empty,
  output logic      full,
  output logic      push_ok,
  output logic      pop_ok,
  output logic      err_left
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  rx_entry_t   mem [DEPTH];
  logic [AW-1:0] wr_p, rd_p;
  logic [AW:0]   cnt_q, err_cnt, err_cnt_nxt;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == DEPTH_C);
  assign push_ok  = push & ~full;
  assign pop_ok   = pop & ~empty;
  assign dout     = empty ? '0 : mem[rd_p];

  always_comb begin
    err_cnt_nxt = err_cnt;
    if (push_ok && entry_has_err(din)) err_cnt_nxt = err_cnt_nxt + 1'b1;
    if (pop_ok && entry_has_err(mem[rd_p])) err_cnt_nxt = err_cnt_nxt - 1'b1;
  end
  assign err_left = (err_cnt_nxt != '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_p] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p    <= '0;
      rd_p    <= '0;
      cnt_q   <= '0;
      err_cnt <= '0;
    end else begin
      if (push_ok) wr_p <= wr_p + 1'b1;
      if (pop_ok)  rd_p <= rd_p + 1'b1;
      cnt_q   <= cnt_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
      err_cnt <= err_cnt_nxt;
    end
  end
endmodule

// File: rtl/uart_lsr.sv
module uart_lsr
  import uart_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stat_rd,
  input  logic      fifo_empty,
  input  rx_entry_t head,
  input  logic      push_ok,
  input  logic      push_err,
  input  logic      pop_ok,
  input  logic      drop_evt,
  input  logic      err_left,
  input  logic      thr_empty_in,
  input  logic      tsr_empty_in,
  output logic [7:0] stat_out
);
  logic thre_q, temt_q, oe_q, mask_q, rxfe_q;
  logic [2:0] head_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_q <= 1'b1;
      temt_q <= 1'b1;
      oe_q   <= 1'b0;
      mask_q <= 1'b0;
      rxfe_q <= 1'b0;
    end else begin
      thre_q <= thr_empty_in;
      temt_q <= thr_empty_in & tsr_empty_in;
      if (drop_evt) oe_q <= 1'b1;
      else if (stat_rd) oe_q <= 1'b0;
      // a new head entry brings its own tags back into view
      if (pop_ok || (push_ok && fifo_empty)) mask_q <= 1'b0;
      else if (stat_rd) mask_q <= 1'b1;
      if (push_ok && push_err) rxfe_q <= 1'b1;
      else if (stat_rd && !err_left) rxfe_q <= 1'b0;
    end
  end

  assign head_tag = (fifo_empty || mask_q) ? 3'b000 : {head.brk, head.ferr, head.perr};
  assign stat_out = {rxfe_q, temt_q, thre_q, head_tag, oe_q, ~fifo_empty};
endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       tick16,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       thr_empty_in,
  input  logic       tsr_empty_in,
  input  logic       stat_rd,
  output logic [7:0] stat_out,
  input  logic       pop,
  output logic [7:0] rx_data
);
  logic      push_req, push_ok, pop_ok, push_err, drop_evt;
  logic      fifo_empty, fifo_full, err_left, brk_hold;
  rx_entry_t push_entry, head;

  uart_rx_core #(.OVS(OVS)) u_core (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick(tick16),
    .par_en(par_en), .par_odd(par_odd),
    .push_req(push_req), .push_entry(push_entry), .brk_hold(brk_hold)
  );

  uart_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_req), .din(push_entry),
    .pop(pop), .dout(head), .empty(fifo_empty), .full(fifo_full),
    .push_ok(push_ok), .pop_ok(pop_ok), .err_left(err_left)
  );

  assign push_err = entry_has_err(push_entry);
  assign drop_evt = push_req & fifo_full;

  uart_lsr u_lsr (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .fifo_empty(fifo_empty),
    .head(head), .push_ok(push_ok), .push_err(push_err), .pop_ok(pop_ok),
    .drop_evt(drop_evt), .err_left(err_left),
    .thr_empty_in(thr_empty_in), .tsr_empty_in(tsr_empty_in),
    .stat_out(stat_out)
  );

  assign rx_data = head.data;
endmodule

// File: rtl/uart_rx_lsr_chk.sv
module uart_rx_lsr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_rd,
  input logic       pop,
  input logic       thr_empty_in,
  input logic [7:0] stat_out,
  input logic       push_req,
  input logic       push_ok,
  input logic       push_err,
  input logic       pop_ok,
  input logic       drop_evt,
  input logic       fifo_empty,
  input logic       brk_hold
);
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> stat_out[1]);

  assert_thre_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stat_out[5] == $past(thr_empty_in));

  assert_temt_needs_thre_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_out[6] |-> stat_out[5]);

  assert_read_clears_tags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !pop_ok && !fifo_empty) |=> (stat_out[4:2] == 3'b000));

  assert_summary_on_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && push_err) |=> stat_out[7]);

  assert_break_no_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_hold |=> !push_req);

  assert_ready_after_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> stat_out[0]);

  assert_empty_pop_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && fifo_empty && !push_ok) |=> !stat_out[0]);
endmodule

bind uart_rx_lsr uart_rx_lsr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .pop(pop),
  .thr_empty_in(thr_empty_in), .stat_out(stat_out),
  .push_req(push_req), .push_ok(push_ok), .push_err(push_err),
  .pop_ok(pop_ok), .drop_evt(drop_evt), .fifo_empty(fifo_empty),
  .brk_hold(brk_hold)
);

// File: tb/uart_rx_lsr_bench.sv
module uart_rx_lsr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1, tick16 = 1'b1, par_en = 1'b0, par_odd = 1'b0;
  logic thr_empty_in = 1'b1, tsr_empty_in = 1'b1, stat_rd = 1'b0, pop = 1'b0;
  logic [7:0] stat_out, rx_data;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_rx_lsr u_uart_rx_lsr (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick16(tick16),
    .par_en(par_en), .par_odd(par_odd), .thr_empty_in(thr_empty_in),
    .tsr_empty_in(tsr_empty_in), .stat_rd(stat_rd), .stat_out(stat_out),
    .pop(pop), .rx_data(rx_data)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // status with both transmitter inputs high
  function automatic logic [7:0] st(input bit rxfe, input bit bi, input bit fe,
                                    input bit pe, input bit oe, input bit dr);
    return {rxfe, 1'b1, 1'b1, bi, fe, pe, oe, dr};
  endfunction

  task automatic send_bit(input logic v);
    rx_in = v;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input bit with_par, input logic pbit,
                           input logic stop_v);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (with_par) send_bit(pbit);
    send_bit(stop_v);
  endtask

  task automatic idle_bits(input int n);
    rx_in = 1'b1;
    repeat (n * 16) @(negedge clk);
  endtask

  task automatic do_read();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check8("R10 reset status", stat_out, 8'h60);

    // R1: every byte value, no parity
    for (int d = 0; d < 256; d++) begin
      send_char(8'(d), 1'b0, 1'b0, 1'b1);
      check8("R1 data", rx_data, 8'(d));
      check8("R8 ready status", stat_out, st(0,0,0,0,0,1));
      do_pop();
      check8("R8 empty after pop", stat_out, 8'h60);
    end

    // R3/R11: parity sweep, both senses, good and bad parity bit
    par_en = 1'b1;
    for (int k = 0; k < 16; k++) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] d;
        logic odd, bad, pb;
        d = 8'(k * 17 + m * 3);
        odd = m[0];
        bad = m[1];
        par_odd = odd;
        pb = (^d) ^ odd ^ bad;
        send_char(d, 1'b1, pb, 1'b1);
        check8("R3 parity data", rx_data, d);
        check8("R3 parity status", stat_out, st(bad,0,0,bad,0,1));
        do_pop();
        do_read();
        check8("R11 summary cleared", stat_out, 8'h60);
      end
    end
    par_en = 1'b0;
    par_odd = 1'b0;

    // R4: bad stop bit, line then stays high -> resync char 0xFF
    send_char(8'hA5, 1'b0, 1'b0, 1'b0);
    idle_bits(11);
    check8("R4 framing data", rx_data, 8'hA5);
    check8("R4 framing status", stat_out, st(1,0,1,0,0,1));
    do_pop();
    check8("R4 resync data", rx_data, 8'hFF);
    check8("R11 summary held until read", stat_out, st(1,0,0,0,0,1));
    do_read();
    check8("R11 summary cleared after read", stat_out, st(0,0,0,0,0,1));
    do_pop();
    check8("R8 empty", stat_out, 8'h60);

    // R6/R7/R11: tags follow the head, read masks the head only
    send_char(8'h22, 1'b0, 1'b0, 1'b0);
    idle_bits(11);
    send_char(8'h33, 1'b0, 1'b0, 1'b1);
    idle_bits(1);
    check8("R6 head data", rx_data, 8'h22);
    check8("R6 head tags", stat_out, st(1,0,1,0,0,1));
    do_read();
    check8("R7 read clears head tags", stat_out, st(1,0,0,0,0,1));
    check8("R7 head unchanged", rx_data, 8'h22);
    do_pop();
    check8("R6 next head data", rx_data, 8'hFF);
    check8("R11 errored gone but unread", stat_out, st(1,0,0,0,0,1));
    do_read();
    check8("R11 cleared", stat_out, st(0,0,0,0,0,1));
    do_pop();
    check8("R6 third entry", rx_data, 8'h33);
    do_pop();
    check8("R8 empty again", stat_out, 8'h60);

    // R5: break held for 30 bit times
    rx_in = 1'b0;
    repeat (30 * 16) @(negedge clk);
    idle_bits(2);
    check8("R5 break data", rx_data, 8'h00);
    check8("R5 break status", stat_out, st(1,1,1,0,0,1));
    do_pop();
    check8("R5 single entry", stat_out, {1'b1, 7'h60});
    do_read();
    check8("R5 read after break", stat_out, 8'h60);
    send_char(8'h5A, 1'b0, 1'b0, 1'b1);
    check8("R5 char after break", rx_data, 8'h5A);
    check8("R5 clean status", stat_out, st(0,0,0,0,0,1));
    do_pop();

    // R2: short low glitch
    rx_in = 1'b0;
    repeat (4) @(negedge clk);
    idle_bits(3);
    check8("R2 false start ignored", stat_out, 8'h60);
    send_char(8'hC3, 1'b0, 1'b0, 1'b1);
    check8("R2 next char", rx_data, 8'hC3);
    do_pop();

    // R9: overrun on the 17th character
    for (int i = 0; i < 17; i++) begin
      send_char(8'(i * 13 + 1), 1'b0, 1'b0, 1'b1);
      if (i == 15) check8("R9 full no overrun", stat_out, st(0,0,0,0,0,1));
    end
    check8("R9 overrun set", stat_out, st(0,0,0,0,1,1));
    for (int i = 0; i < 16; i++) begin
      check8("R9 kept data", rx_data, 8'(i * 13 + 1));
      do_pop();
    end
    check8("R9 overrun sticky", stat_out, 8'h62);
    do_read();
    check8("R9 read clears overrun", stat_out, 8'h60);

    // R10: transmitter status inputs
    for (int c = 0; c < 4; c++) begin
      thr_empty_in = c[0];
      tsr_empty_in = c[1];
      @(negedge clk);
      check8("R10 tx flags", stat_out, {1'b0, c[0] & c[1], c[0], 5'b0});
    end
    thr_empty_in = 1'b1;
    tsr_empty_in = 1'b1;
    @(negedge clk);

    // R8: pop on empty has no effect
    do_pop();
    check8("R8 empty pop", stat_out, 8'h60);
    send_char(8'h7E, 1'b0, 1'b0, 1'b1);
    check8("R8 data after empty pop", rx_data, 8'h7E);
    check8("R8 one entry", stat_out, st(0,0,0,0,0,1));
    do_pop();
    check8("R8 drained", stat_out, 8'h60);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule